// File: doc/BRIEF.md
# I2C Bus Clear Sequencer

This block frees an I2C bus after a target has stalled partway through a byte and is holding SDA low. The controller reaches this state in two ways: the bus stays busy past a timeout, or a transfer times out. The controller then pulses `startReq`. The sequencer takes over both lines through open-drain style pull-down enables and runs nine SCL clock pulses. It leaves SDA released during the pulses, so the stuck target sees a NACK and lets go of the line. It then forms a STOP condition and reports completion with a single-cycle `done` pulse, after which the controller reinitialises itself.

Timing is set in system clock cycles. `halfPeriod` gives the length of every low phase and every high phase of SCL, and of each step of the STOP. The value is captured when a run starts, so a new setting applies only to the next run. After the STOP's final release the sequencer reads `sdaIn`. It reports completion only once the data line is actually seen high, so a target that still holds SDA low keeps the block busy.

Top module: `bus_clear_seq`

## Requirements
- R1: During reset and whenever the block is idle, `sclDriveLow`, `sdaDriveLow`, `busy` and `done` are all 0 (both lines released).
- R2: A `startReq` sampled while idle makes `busy` and `sclDriveLow` both 1 in the cycle that follows that clock edge.
- R3: A run pulls SCL low exactly nine separate times before the STOP begins (parameter PULSES, default 9).
- R4: With h = the captured half-period, each SCL low phase and each SCL high phase of the burst lasts exactly h cycles, starting with a low phase.
- R5: `sdaDriveLow` stays 0 for the whole pulse burst (the data line is left released, giving a NACK).
- R6: After the burst, the STOP runs in this order, each step lasting h cycles: SCL and SDA both pulled low, then SCL released while SDA is still pulled low, then SDA released. SDA is only ever pulled low while SCL is pulled low.
- R7: `done` is raised only after the release step has lasted at least h cycles and `sdaIn` has been sampled as 1 at a clock edge. If SDA is held low longer, `busy` stays 1 until it is seen high.
- R8: `done` is 1 for exactly one cycle. `busy` stays 1 from the cycle after start up to the cycle before `done`, and is 0 in the `done` cycle.
- R9: A `startReq` sampled while busy is ignored, and the run's waveform is unchanged.
- R10: `halfPeriod` is captured at start. Changing it during a run does not alter that run's timing.
- R11: A `halfPeriod` of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request to begin a recovery run |
| sdaIn | input | 1 | Synchronised level of the SDA line |
| halfPeriod | input | CNT_W | Half-period of SCL in clock cycles |
| sclDriveLow | output | 1 | 1 pulls SCL low, 0 releases it |
| sdaDriveLow | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench compares every cycle of a run against a waveform it computes from h. It runs the shortest half-period and longer ones. A counter that wraps one cycle early or late shows up as a burst that is too short or too long, or as an eighth or tenth pulse. It also runs a zero setting, where a design that does not clamp it would sit in the first low phase until the counter wrapped. A target that keeps SDA low after the STOP must delay `done`; a design that ignores `sdaIn` would finish early. One run injects start requests and a new half-period partway through. A design that restarts, or that does not capture the setting, would bend that run's waveform.

// File: rtl/bus_clear_pkg.sv
package bus_clear_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LOW   = 3'd1,
    PH_HIGH  = 3'd2,
    PH_SETUP = 3'd3,
    PH_HOLD  = 3'd4,
    PH_REL   = 3'd5
  } phase_t;

  // strobes from control to datapath; line/status fields are the values
  // the datapath registers present for the next cycle
  typedef struct packed {
    logic loadCfg;
    logic clearCnt;
    logic sclLow;
    logic sdaLow;
    logic busy;
    logic done;
  } strobe_t;

endpackage

// File: rtl/bus_clear_dp.sv
module bus_clear_dp #(
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  bus_clear_pkg::strobe_t    strb,
  input  logic [CNT_W-1:0]          halfPeriod,
  output logic                      phaseEnd,
  output logic                      sclDriveLow,
  output logic                      sdaDriveLow,
  output logic                      busy,
  output logic                      done
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] halfLatched;
  logic [CNT_W-1:0] tickCnt;

  assign phaseEnd = (tickCnt == (halfLatched - ONE));

  // captured half-period; zero is clamped to one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfLatched <= ONE;
    end else if (strb.loadCfg) begin
      halfLatched <= (halfPeriod == '0) ? ONE : halfPeriod;
    end
  end

  // phase tick counter, saturates at the phase end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strb.clearCnt) begin
      tickCnt <= '0;
    end else if (!phaseEnd) begin
      tickCnt <= tickCnt + ONE;
    end
  end

  // registered line drives and status
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclDriveLow <= 1'b0;
      sdaDriveLow <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
    end else begin
      sclDriveLow <= strb.sclLow;
      sdaDriveLow <= strb.sdaLow;
      busy        <= strb.busy;
      done        <= strb.done;
    end
  end

  // R4: the tick counter never runs past the captured half-period
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (tickCnt < halfLatched));

  // R11: the captured half-period is never zero
  p_half_nonzero_r11: assert property (@(posedge clk) disable iff (!rstN)
    halfLatched != '0);

endmodule

// File: rtl/bus_clear_ctrl.sv
module bus_clear_ctrl #(
  parameter int PULSES = 9
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      startReq,
  input  logic                      sdaIn,
  input  logic                      phaseEnd,
  output bus_clear_pkg::strobe_t    strb
);
  import bus_clear_pkg::*;

  localparam int IDX_W = (PULSES > 1) ? $clog2(PULSES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PULSES - 1);

  phase_t          state, nextState;
  logic [IDX_W-1:0] pulseIdx;
  logic            incIdx, clrIdx, finish;

  always_comb begin
    nextState     = state;
    incIdx        = 1'b0;
    clrIdx        = 1'b0;
    finish        = 1'b0;
    strb.loadCfg  = 1'b0;
    strb.clearCnt = 1'b0;
    unique case (state)
      PH_IDLE: begin
        if (startReq) begin
          nextState     = PH_LOW;
          strb.loadCfg  = 1'b1;
          strb.clearCnt = 1'b1;
          clrIdx        = 1'b1;
        end
      end
      PH_LOW: begin
        if (phaseEnd) begin
          nextState     = PH_HIGH;
          strb.clearCnt = 1'b1;
        end
      end
      PH_HIGH: begin
        if (phaseEnd) begin
          strb.clearCnt = 1'b1;
          if (pulseIdx == LAST_IDX) begin
            nextState = PH_SETUP;
          end else begin
            nextState = PH_LOW;
            incIdx    = 1'b1;
          end
        end
      end
      PH_SETUP: begin
        if (phaseEnd) begin
          nextState     = PH_HOLD;
          strb.clearCnt = 1'b1;
        end
      end
      PH_HOLD: begin
        if (phaseEnd) begin
          nextState     = PH_REL;
          strb.clearCnt = 1'b1;
        end
      end
      PH_REL: begin
        if (phaseEnd && sdaIn) begin
          nextState = PH_IDLE;
          finish    = 1'b1;
        end
      end
      default: nextState = PH_IDLE;
    endcase
    strb.sclLow = (nextState == PH_LOW) || (nextState == PH_SETUP);
    strb.sdaLow = (nextState == PH_SETUP) || (nextState == PH_HOLD);
    strb.busy   = (nextState != PH_IDLE);
    strb.done   = finish;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= PH_IDLE;
      pulseIdx <= '0;
    end else begin
      state <= nextState;
      if (clrIdx) begin
        pulseIdx <= '0;
      end else if (incIdx) begin
        pulseIdx <= pulseIdx + 1'b1;
      end
    end
  end

  // R3: the pulse index never goes past the last pulse
  p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    pulseIdx <= LAST_IDX);

  // R4: a low phase is left only when the datapath signals its end
  p_low_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_LOW && !phaseEnd) |=> (state == PH_LOW));

  // R9: a start request during a run does not return the control to the first pulse
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_HOLD && startReq && !phaseEnd) |=> (state == PH_HOLD));

endmodule

// File: rtl/bus_clear_seq.sv
module bus_clear_seq #(
  parameter int CNT_W  = 16,
  parameter int PULSES = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             sdaIn,
  input  logic [CNT_W-1:0] halfPeriod,
  output logic             sclDriveLow,
  output logic             sdaDriveLow,
  output logic             busy,
  output logic             done
);
  import bus_clear_pkg::*;

  strobe_t strb;
  logic    phaseEnd;

  bus_clear_ctrl #(.PULSES(PULSES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .sdaIn    (sdaIn),
    .phaseEnd (phaseEnd),
    .strb     (strb)
  );

  bus_clear_dp #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .halfPeriod  (halfPeriod),
    .phaseEnd    (phaseEnd),
    .sclDriveLow (sclDriveLow),
    .sdaDriveLow (sdaDriveLow),
    .busy        (busy),
    .done        (done)
  );

  // R1: when not busy both lines are released
  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclDriveLow && !sdaDriveLow));

  // R8: done lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: busy drops in the done cycle, having been high before it
  p_done_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R7: completion only follows a cycle in which SDA was seen high
  p_done_sda_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(sdaIn));

  // R6: SDA is only pulled down while SCL is pulled down
  p_sda_fall_scl_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> sclDriveLow);

endmodule

// File: tb/bus_clear_seq_tb.sv
module bus_clear_seq_tb;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic          sdaIn = 1'b1;
  logic [CW-1:0] halfPeriod = '0;
  logic          sclDriveLow, sdaDriveLow, busy, done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bus_clear_seq #(.CNT_W(CW), .PULSES(9)) u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .sdaIn       (sdaIn),
    .halfPeriod  (halfPeriod),
    .sclDriveLow (sclDriveLow),
    .sdaDriveLow (sdaDriveLow),
    .busy        (busy),
    .done        (done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check({sclDriveLow, sdaDriveLow, busy, done} == 4'b0, "R1", "outputs in reset",
          int'({sclDriveLow, sdaDriveLow, busy, done}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check({sclDriveLow, sdaDriveLow, busy, done} == 4'b0, "R1", "outputs idle after reset",
          int'({sclDriveLow, sdaDriveLow, busy, done}), 0);
  endtask

  // one full run; expected waveform derived from the requirements
  task automatic runScenario(input string name, input int h, input int sdaHighAt,
                             input bit disturb);
    int hE;
    int doneCyc;
    int lowEdges;
    int errScl, errSda, errStop, errDone;
    bit prevScl;
    bit firstOk;
    bit sclExp, sdaExp;
    hE = (h == 0) ? 1 : h;
    doneCyc = (((21 * hE - 1) > sdaHighAt) ? (21 * hE - 1) : sdaHighAt) + 1;
    lowEdges = 0; errScl = 0; errSda = 0; errStop = 0; errDone = 0;
    prevScl = 1'b0; firstOk = 1'b0;
    halfPeriod = CW'(h);
    startReq = 1'b1;
    sdaIn = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    for (int t = 0; t <= doneCyc + 1; t++) begin
      if (t < 18 * hE) begin
        sclExp = ((t / hE) % 2) == 0;
        sdaExp = 1'b0;
      end else if (t < 19 * hE) begin
        sclExp = 1'b1; sdaExp = 1'b1;
      end else if (t < 20 * hE) begin
        sclExp = 1'b0; sdaExp = 1'b1;
      end else begin
        sclExp = 1'b0; sdaExp = 1'b0;
      end
      if (t == 0) firstOk = busy && sclDriveLow;
      if (t < 18 * hE) begin
        if (sclDriveLow !== sclExp || busy !== 1'b1 || done !== 1'b0) errScl++;
        if (sdaDriveLow !== 1'b0) errSda++;
        if (sclDriveLow && !prevScl) lowEdges++;
      end else if (t < doneCyc) begin
        if (sclDriveLow !== sclExp || sdaDriveLow !== sdaExp || busy !== 1'b1 || done !== 1'b0)
          errStop++;
      end else begin
        if (busy !== 1'b0 || done !== (t == doneCyc) || sclDriveLow || sdaDriveLow) errDone++;
      end
      prevScl = sclDriveLow;
      sdaIn = (t >= sdaHighAt);
      startReq = disturb && (t == 5 || t == 18 * hE + 1);
      if (disturb && t == 3) halfPeriod = CW'(7);
      @(negedge clk);
    end
    sdaIn = 1'b1;
    startReq = 1'b0;
    check(firstOk, "R2", {name, ": busy and SCL low after start"}, int'(firstOk), 1);
    check(lowEdges == 9, "R3", {name, ": SCL low pulses"}, lowEdges, 9);
    check(errScl == 0, "R4", {name, ": burst phase timing mismatches"}, errScl, 0);
    check(errSda == 0, "R5", {name, ": SDA driven during burst"}, errSda, 0);
    check(errStop == 0, "R6", {name, ": STOP step mismatches"}, errStop, 0);
    check(errDone == 0, "R7", {name, ": completion timing mismatches"}, errDone, 0);
    check(errDone == 0, "R8", {name, ": done pulse and busy end"}, errDone, 0);
  endtask

  task automatic testShort();
    runScenario("h1", 1, 0, 1'b0);
  endtask

  task automatic testLonger();
    runScenario("h3", 3, 0, 1'b0);
  endtask

  task automatic testZeroHalf();
    // R11: zero setting must behave exactly like one
    runScenario("R11 h0", 0, 0, 1'b0);
  endtask

  task automatic testStuckSda();
    // R7: target keeps SDA low well past the release step
    runScenario("R7 stuck", 2, 21 * 2 + 6, 1'b0);
  endtask

  task automatic testDisturb();
    // R9 and R10: extra starts and a new half-period during the run
    runScenario("R9 R10 disturbed", 4, 0, 1'b0 | 1'b1);
    check(busy == 1'b0, "R9", "idle after disturbed run", int'(busy), 0);
    halfPeriod = CW'(2);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    testShort();
    testLonger();
    testZeroHalf();
    testStuckSda();
    testDisturb();
    testShort();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule